// File: doc/BRIEF.md
# Shared-Bus SRAM Adapter

This block lets a single asynchronous 16-bit SRAM stand in for a memory system that was built for dynamic RAM. On the bus side it sees active-low row and column strobes, a multiplexed address, a read/write level, active-low upper and lower byte strobes, and a flag that marks the video half of each bus cycle. The CPU owns one half of every cycle and may read or write. The video fetch engine owns the other half and only reads. The video engine never drives the byte strobes, so reads cannot depend on them.

The bus controls and the address are registered once on every clock edge. The row half of the address is captured on the first cycle the row strobe is seen active, and the column half on the first cycle the column strobe is seen active. The SRAM word address is the two halves joined together. A 2-bit jumper value gives the installed memory size in 512 KiB steps. When the row address lies past that size, both strobes are suppressed before they reach the SRAM controls. The chip then stays deselected and a read returns all ones.

Top module: `sram_bridge`

## Requirements
- R1: `sram_ce_n` is low in a cycle only if row and column strobes were both sampled low at the previous clock edge and the access is in range.
- R2: When `bus_rd` was sampled high (read), `sram_ub_n` and `sram_lb_n` are both low, whatever the byte strobes are.
- R3: In a CPU-half write (`bus_rd` low, `bus_video` low), `sram_ub_n` follows `bus_ub_n` and `sram_lb_n` follows `bus_lb_n`, one clock later.
- R4: A video-half cycle (`bus_video` high) never asserts `sram_we_n`, even with `bus_rd` low, and the SRAM contents are unchanged.
- R5: `sram_we_n` is low only while at least one byte strobe is held low. It rises one clock after the strobes are released, even if `bus_rd` stays low.
- R6: `size_sel` value n (0..3) allows (n+1)×512 KiB. An access whose row address top two bits exceed n does not enable the SRAM and writes nothing.
- R7: `sram_addr` = {row half, column half}, each captured from `bus_addr` (10 bits) on the first sampled-active cycle of its strobe and held while that strobe stays low.
- R8: `sram_dq` is driven with the registered write data only while chip enable and write enable are both low.
- R9: An in-range read returns the full 16-bit word stored at the address. An out-of-range or idle read returns 16'hFFFF.

Top module ports follow; all outputs except `bus_rdata` change one clock after the bus inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than the bus strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_row_n | input | 1 | Row strobe, active low |
| bus_col_n | input | 1 | Column strobe, active low |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_ub_n | input | 1 | Upper byte strobe, active low |
| bus_lb_n | input | 1 | Lower byte strobe, active low |
| bus_video | input | 1 | 1 = video half of the bus cycle |
| bus_addr | input | 10 | Multiplexed row/column address |
| bus_wdata | input | 16 | Write data from the bus |
| bus_rdata | output | 16 | Read data to the bus (all ones when not enabled) |
| size_sel | input | 2 | Installed size, (n+1)×512 KiB |
| sram_addr | output | 20 | SRAM word address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_ub_n | output | 1 | SRAM upper byte enable, active low |
| sram_lb_n | output | 1 | SRAM lower byte enable, active low |
| sram_dq | inout | 16 | SRAM data bus |

## Verification
Some relations are checked on every cycle against the bus inputs of the previous edge. These are: chip enable needing both strobes, both byte enables forced during reads, byte enables passed through on CPU writes, no write in the video half, and write enable confined to the byte-strobe window. The address bank is also checked against the size selection, and the hold of the captured row half. Only the bench scenarios can show what ends up in memory. They cover partial-byte merges, video-half write attempts that leave data untouched, and out-of-range writes that do not alias into lower memory. They also cover the all-ones return at the exact boundary rows for each size setting.

// File: rtl/sramb_pkg.sv
// Package: shared constants for the shared-bus SRAM adapter.
// Assumes a 16-bit data path split into two byte lanes (index 1 = upper).
package sramb_pkg;
    localparam int LANES = 2;
    localparam int LANE_UPPER = 1;
    localparam int LANE_LOWER = 0;
endpackage

// File: rtl/sramb_capture.sv
// Module: sramb_capture
// Registers the bus control levels, write data and size jumpers once per
// clock. It captures the row and column halves of the multiplexed address
// on the first cycle each strobe is seen active.
// Assumes the strobes are much slower than clk and the row half comes first.
module sramb_capture #(
    parameter int HALF_W = 10,
    parameter int DATA_W = 16,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_n,
    input  logic              col_n,
    input  logic              rd,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic              video,
    input  logic [HALF_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SIZE_W-1:0] size_sel,
    output logic              row_act_q,
    output logic              col_act_q,
    output logic              rd_q,
    output logic              video_q,
    output logic [1:0]        lane_act_q,
    output logic [HALF_W-1:0] row_q,
    output logic [HALF_W-1:0] col_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [SIZE_W-1:0] size_q
);
    // Purpose: sample the bus control levels and data; reset to an idle read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_act_q  <= 1'b0;
            col_act_q  <= 1'b0;
            rd_q       <= 1'b1;
            video_q    <= 1'b0;
            lane_act_q <= '0;
            wdata_q    <= '0;
            size_q     <= '0;
        end else begin
            row_act_q  <= !row_n;
            col_act_q  <= !col_n;
            rd_q       <= rd;
            video_q    <= video;
            lane_act_q <= {!ub_n, !lb_n};
            wdata_q    <= wdata;
            size_q     <= size_sel;
        end
    end

    // Purpose: capture each address half at the onset of its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (!row_n && !row_act_q) row_q <= addr;
            if (!col_n && !col_act_q) col_q <= addr;
        end
    end

    // The row half must stay put while the row strobe remains active.
    p_row_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_act_q && $past(row_act_q) && $past(rst_n)) |-> $stable(row_q));
    p_col_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_act_q && $past(col_act_q) && $past(rst_n)) |-> $stable(col_q));
endmodule

// File: rtl/sramb_window.sv
// Module: sramb_window
// Suppresses the row and column strobes when the captured row address
// falls outside the installed size. Each size step is one 2^(HALF_W-SIZE_W)
// block of rows. Assumes the installed size grows from address zero.
module sramb_window #(
    parameter int HALF_W = 10,
    parameter int SIZE_W = 2
) (
    input  logic              row_act,
    input  logic              col_act,
    input  logic [HALF_W-1:0] row,
    input  logic [SIZE_W-1:0] size,
    output logic              g_row,
    output logic              g_col,
    output logic              in_range
);
    localparam int BANK_LSB = HALF_W - SIZE_W;

    logic [SIZE_W-1:0] bank;

    // Purpose: compare the row bank with the selected size and gate strobes.
    always_comb begin
        bank     = row[HALF_W-1:BANK_LSB];
        in_range = (bank <= size);
        g_row    = row_act && in_range;
        g_col    = col_act && in_range;
    end
endmodule

// File: rtl/sramb_drive.sv
// Module: sramb_drive
// Forms the SRAM chip enable, write enable, per-lane byte enables and the
// data bus drive from the gated strobes. Assumes the inputs are registered.
module sramb_drive #(
    parameter int DATA_W = 16
) (
    input  logic              g_row,
    input  logic              g_col,
    input  logic              rd,
    input  logic              video,
    input  logic [1:0]        lane_act,
    input  logic [DATA_W-1:0] wdata,
    output logic              ce_n,
    output logic              we_n,
    output logic [1:0]        be_n,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out
);
    import sramb_pkg::*;

    logic cpu_write;
    logic ce;
    logic we;

    // Purpose: chip enable needs both gated strobes; a write needs CPU half and a byte strobe.
    always_comb begin
        cpu_write = !rd && !video;
        ce        = g_row && g_col;
        we        = ce && cpu_write && (|lane_act);
        ce_n      = !ce;
        we_n      = !we;
        dq_oe     = ce && we;
        dq_out    = wdata;
    end

    // Purpose: per-lane enable, forced on for reads and followed on writes.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be_n[i] = cpu_write ? !lane_act[i] : 1'b0;
    end
endmodule

// File: rtl/sram_bridge.sv
// Module: sram_bridge (top)
// Connects a time-shared row/column-strobe memory bus to one asynchronous
// 16-bit SRAM. Chain: capture -> size window -> SRAM drive.
// Assumes one SRAM covers the largest size setting and that the sampling
// clock gives several cycles per strobe phase.
module sram_bridge #(
    parameter int HALF_W = 10,
    parameter int DATA_W = 16,
    parameter int SIZE_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_row_n,
    input  logic                bus_col_n,
    input  logic                bus_rd,
    input  logic                bus_ub_n,
    input  logic                bus_lb_n,
    input  logic                bus_video,
    input  logic [HALF_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [SIZE_W-1:0]   size_sel,
    output logic [2*HALF_W-1:0] sram_addr,
    output logic                sram_ce_n,
    output logic                sram_we_n,
    output logic                sram_ub_n,
    output logic                sram_lb_n,
    inout  wire  [DATA_W-1:0]   sram_dq
);
    import sramb_pkg::*;

    localparam int ADDR_W = 2 * HALF_W;

    logic              row_act_q, col_act_q, rd_q, video_q;
    logic [1:0]        lane_act_q;
    logic [HALF_W-1:0] row_q, col_q;
    logic [DATA_W-1:0] wdata_q;
    logic [SIZE_W-1:0] size_q;
    logic              g_row, g_col, in_range;
    logic [1:0]        be_n;
    logic              dq_oe;
    logic [DATA_W-1:0] dq_out;

    sramb_capture #(.HALF_W(HALF_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .row_n(bus_row_n), .col_n(bus_col_n), .rd(bus_rd),
        .ub_n(bus_ub_n), .lb_n(bus_lb_n), .video(bus_video),
        .addr(bus_addr), .wdata(bus_wdata), .size_sel(size_sel),
        .row_act_q(row_act_q), .col_act_q(col_act_q), .rd_q(rd_q),
        .video_q(video_q), .lane_act_q(lane_act_q),
        .row_q(row_q), .col_q(col_q), .wdata_q(wdata_q), .size_q(size_q)
    );

    sramb_window #(.HALF_W(HALF_W), .SIZE_W(SIZE_W)) u_window (
        .row_act(row_act_q), .col_act(col_act_q), .row(row_q), .size(size_q),
        .g_row(g_row), .g_col(g_col), .in_range(in_range)
    );

    sramb_drive #(.DATA_W(DATA_W)) u_drive (
        .g_row(g_row), .g_col(g_col), .rd(rd_q), .video(video_q),
        .lane_act(lane_act_q), .wdata(wdata_q),
        .ce_n(sram_ce_n), .we_n(sram_we_n), .be_n(be_n),
        .dq_oe(dq_oe), .dq_out(dq_out)
    );

    // Purpose: word address, lane enables, data bus drive and read return.
    assign sram_addr = {row_q, col_q};
    assign sram_ub_n = be_n[LANE_UPPER];
    assign sram_lb_n = be_n[LANE_LOWER];
    assign sram_dq   = dq_oe ? dq_out : 'z;
    assign bus_rdata = sram_ce_n ? '1 : sram_dq;

    p_ce_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !sram_ce_n) |-> $past(!bus_row_n && !bus_col_n));
    p_ce_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> in_range);
    p_read_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_rd)) |-> (!sram_ub_n && !sram_lb_n));
    p_write_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!bus_rd && !bus_video))
        |-> (sram_ub_n == $past(bus_ub_n) && sram_lb_n == $past(bus_lb_n)));
    p_video_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_video)) |-> sram_we_n);
    p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !sram_we_n) |-> $past(!bus_ub_n || !bus_lb_n));
    p_size_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !sram_ce_n)
        |-> (sram_addr[ADDR_W-1 -: SIZE_W] <= $past(size_sel)));
    p_drive_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n);
endmodule

// File: tb/sim_sram_bridge.sv
`timescale 1ns/1ps
module sim_sram_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_row_n = 1'b1, bus_col_n = 1'b1, bus_rd = 1'b1;
    logic        bus_ub_n = 1'b1, bus_lb_n = 1'b1, bus_video = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  size_sel = 2'd3;
    logic [19:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_ub_n, sram_lb_n;
    wire  [15:0] sram_dq;
    logic [15:0] rd_val = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model state (behavioural, from the requirements).
    bit          m_ra, m_ca, m_rd, m_ub, m_lb, m_vid;
    logic [9:0]  m_row, m_col;
    logic [15:0] m_wd;
    int          m_size;
    logic [15:0] exp_mem [int];
    logic [15:0] chip_mem [int];

    always #2.5 clk = ~clk;

    sram_bridge u0 (
        .clk(clk), .rst_n(rst_n), .bus_row_n(bus_row_n), .bus_col_n(bus_col_n),
        .bus_rd(bus_rd), .bus_ub_n(bus_ub_n), .bus_lb_n(bus_lb_n),
        .bus_video(bus_video), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .size_sel(size_sel), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n),
        .sram_lb_n(sram_lb_n), .sram_dq(sram_dq)
    );

    // Behavioural asynchronous SRAM.
    assign sram_dq = (!sram_ce_n && sram_we_n) ? rd_val : 'z;

    always @(posedge clk) begin
        #1;
        rd_val = chip_mem.exists(int'(sram_addr)) ? chip_mem[int'(sram_addr)] : 16'h0000;
    end

    always @(negedge clk) begin
        if (!sram_ce_n && !sram_we_n) begin
            logic [15:0] w;
            w = chip_mem.exists(int'(sram_addr)) ? chip_mem[int'(sram_addr)] : 16'h0000;
            if (!sram_ub_n) w[15:8] = sram_dq[15:8];
            if (!sram_lb_n) w[7:0]  = sram_dq[7:0];
            chip_mem[int'(sram_addr)] = w;
        end
    end

    function automatic logic [15:0] exp_word(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ra = 0; m_ca = 0; m_rd = 1; m_ub = 0; m_lb = 0; m_vid = 0;
        m_row = '0; m_col = '0; m_wd = '0; m_size = 0;
    endtask

    // One clock: drive inputs, advance the model at the edge, compare at negedge.
    task automatic step(input bit rown, input bit coln, input bit rd, input bit ubn,
                        input bit lbn, input bit vid, input logic [9:0] a,
                        input logic [15:0] wd);
        bit e_in, e_ce, e_wr, e_we;
        int ea;
        logic [15:0] w;
        bus_row_n = rown; bus_col_n = coln; bus_rd = rd; bus_ub_n = ubn;
        bus_lb_n = lbn; bus_video = vid; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        if (!rown && !m_ra) m_row = a;
        if (!coln && !m_ca) m_col = a;
        m_ra = !rown; m_ca = !coln; m_rd = rd; m_ub = !ubn; m_lb = !lbn;
        m_vid = vid; m_wd = wd; m_size = int'(size_sel);
        e_in = (int'(m_row) / 256) <= m_size;
        e_ce = m_ra && m_ca && e_in;
        e_wr = !m_rd && !m_vid;
        e_we = e_ce && e_wr && (m_ub || m_lb);
        ea = int'(m_row) * 1024 + int'(m_col);
        if (e_we) begin
            w = exp_word(ea);
            if (m_ub) w[15:8] = m_wd[15:8];
            if (m_lb) w[7:0]  = m_wd[7:0];
            exp_mem[ea] = w;
        end
        @(negedge clk);
        chk(sram_ce_n == !e_ce, "R1/R6 chip enable", sram_ce_n, !e_ce);
        chk(sram_we_n == !e_we, "R4/R5 write enable", sram_we_n, !e_we);
        if (e_wr) begin
            chk(sram_ub_n == !m_ub, "R3 upper enable follows strobe", sram_ub_n, !m_ub);
            chk(sram_lb_n == !m_lb, "R3 lower enable follows strobe", sram_lb_n, !m_lb);
        end else begin
            chk(!sram_ub_n && !sram_lb_n, "R2 both enables on read",
                {sram_ub_n, sram_lb_n}, 2'b00);
        end
        if (e_ce) chk(sram_addr == {m_row, m_col}, "R7 word address", sram_addr, {m_row, m_col});
        if (e_we) chk(sram_dq == m_wd, "R8 data bus drive", sram_dq, m_wd);
        if (e_ce && !e_we)
            chk(bus_rdata == exp_word(ea), "R9 full word read", bus_rdata, exp_word(ea));
        if (!e_ce) chk(bus_rdata == 16'hFFFF, "R9 all ones when not enabled", bus_rdata, 16'hFFFF);
    endtask

    // One bus access; byte strobes are released before the column strobe (R5).
    task automatic access(input bit rd, input bit vid, input logic [9:0] row,
                          input logic [9:0] col, input logic [15:0] wd,
                          input bit ubn, input bit lbn);
        step(1, 1, rd, 1, 1, vid, row, wd);
        step(0, 1, rd, 1, 1, vid, row, wd);
        step(0, 0, rd, ubn, lbn, vid, col, wd);
        step(0, 0, rd, ubn, lbn, vid, col, wd);
        step(0, 0, rd, 1, 1, vid, col, wd);
        step(0, 0, rd, 1, 1, vid, col, wd);
        step(1, 1, 1, 1, 1, vid, col, wd);
    endtask

    initial begin
        #500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: R1 deselected, R2 both enables, R9 all ones.
        chk(sram_ce_n && sram_we_n, "R1 reset deselected", {sram_ce_n, sram_we_n}, 2'b11);
        chk(!sram_ub_n && !sram_lb_n, "R2 reset enables", {sram_ub_n, sram_lb_n}, 2'b00);
        chk(bus_rdata == 16'hFFFF, "R9 reset read value", bus_rdata, 16'hFFFF);
        rst_n = 1'b1;
        m_size = 3;

        // Full size: word writes, partial lanes, reads.
        access(0, 0, 10'h005, 10'h00A, 16'h1234, 0, 0);
        access(1, 0, 10'h005, 10'h00A, 16'h0000, 1, 1);
        access(0, 0, 10'h005, 10'h00A, 16'hCDEF, 0, 1);
        access(0, 0, 10'h005, 10'h00A, 16'h9876, 1, 0);
        access(1, 0, 10'h005, 10'h00A, 16'h0000, 0, 1);
        // Video half: read with no byte strobes, then an ignored write attempt (R4).
        access(1, 1, 10'h005, 10'h00A, 16'h0000, 1, 1);
        access(0, 1, 10'h005, 10'h00A, 16'hDEAD, 0, 0);
        access(1, 0, 10'h005, 10'h00A, 16'h0000, 1, 1);
        // Top word and a bank-2 word for the size tests.
        access(0, 0, 10'h3FF, 10'h3FF, 16'hA5A5, 0, 0);
        access(0, 0, 10'h200, 10'h001, 16'h5A5A, 0, 0);
        access(1, 0, 10'h3FF, 10'h3FF, 16'h0000, 1, 1);

        // Smallest size: row 0x100 is out of range (R6), 0x0FF is inside.
        size_sel = 2'd0;
        access(0, 0, 10'h100, 10'h002, 16'hBEEF, 0, 0);
        access(1, 0, 10'h100, 10'h002, 16'h0000, 1, 1);
        access(0, 0, 10'h0FF, 10'h3FF, 16'h0F0F, 0, 0);
        access(1, 0, 10'h0FF, 10'h3FF, 16'h0000, 1, 1);
        access(1, 1, 10'h3FF, 10'h3FF, 16'h0000, 1, 1);

        // 1 MiB: boundary rows 0x1FF (in) and 0x200 (out).
        size_sel = 2'd1;
        access(0, 0, 10'h1FF, 10'h000, 16'h7777, 0, 0);
        access(1, 0, 10'h1FF, 10'h000, 16'h0000, 1, 1);
        access(1, 0, 10'h200, 10'h001, 16'h0000, 1, 1);
        access(0, 0, 10'h200, 10'h001, 16'h1111, 0, 0);

        // Back to full size: the suppressed writes left memory untouched (R6).
        size_sel = 2'd3;
        access(1, 0, 10'h100, 10'h002, 16'h0000, 1, 1);
        access(1, 0, 10'h200, 10'h001, 16'h0000, 0, 0);
        access(1, 1, 10'h0FF, 10'h3FF, 16'h0000, 1, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule